// File: doc/BRIEF.md
# Line 21 Caption Bit Serializer

This block produces the digital bit sequence for closed-caption and extended-data service on the caption line of each video field. A small write port loads four byte registers: a caption pair used in odd fields and an extended-data pair used in even fields. A downstream waveform shaper turns the resulting bit stream into the analog line signal.

A frame starts on a line-start strobe that arrives while the caption-line input is high. The block then emits a stream of 33 bits, each held for a programmable number of system clocks, and qualifies the whole stream with a valid signal. The stream is a clock run-in of alternating ones and zeros, then a fixed start code, then the two bytes of the current field, each sent least significant bit first. Bit 7 of each byte carries the parity and is sent exactly as written. The byte pair, the field choice and the bit period are all captured when the frame starts, so writes made during a line only affect a later line.

Top module: `cc_line_serializer`

## Requirements
- R1: After reset `ser_valid` and `ser_bit` are 0, and all four byte registers hold 8'h80.
- R2: A write with `wr_en` high stores `wr_data` in the register chosen by `wr_addr`: 0 = odd-field first byte, 1 = odd-field second byte, 2 = even-field first byte, 3 = even-field second byte.
- R3: A `line_start` pulse sampled while `cap_line` is high and no frame is running starts a frame. `ser_valid` rises in the next cycle and stays high for exactly 33 bit periods.
- R4: The first 14 bits of a frame alternate 1,0,1,0,… starting with 1. The next three bits are 0, 0, 1.
- R5: When `field_odd` is 1 at the start, bits 17 to 32 carry bytes 0 and 1. When it is 0, they carry bytes 2 and 3.
- R6: Each byte goes out least significant bit first with all 8 bits, bit 7 as written. There is no gap after the start code or between the bytes.
- R7: A bit lasts `bit_clks` clock cycles. A value of 0 selects the parameter `DEF_BIT_CLKS` (54 by default, about 32 bits per line).
- R8: A `line_start` pulse while a frame runs, or while `cap_line` is low, has no effect on the outputs.
- R9: Bytes, field and bit period are captured at frame start. A write in the same cycle as the start, or during the frame, does not change the current frame and appears in the next frame of that field.
- R10: `ser_bit` is 0 whenever `ser_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Byte register select |
| wr_data | input | 8 | Byte to store |
| field_odd | input | 1 | 1 in odd fields, 0 in even fields |
| cap_line | input | 1 | High while the current line is the caption line |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| bit_clks | input | DIV_W (8) | Clocks per bit; 0 selects the default |
| ser_valid | output | 1 | High while the frame bits are being sent |
| ser_bit | output | 1 | Current serial bit |

## Verification
Two things can happen in the same clock edge: a register write and the start of a frame. A later write can also overlap a running frame, as can a second start strobe. The bench drives a write in the very cycle of the start strobe and expects the frame to carry the old byte, with the new byte showing up only in the next frame of that field. During frames it also writes registers, toggles the field and period inputs and pulses `line_start`, and it compares every cycle of the stream against a frame built in the bench from the byte values captured at the start.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int RUNIN_BITS = 14;
   localparam int START_BITS = 3;
   localparam int BYTE_BITS  = 8;
   localparam int FRAME_LEN  = RUNIN_BITS + START_BITS + 2 * BYTE_BITS;
   localparam int NUM_REGS   = 4;

   typedef logic [FRAME_LEN-1:0] frame_t;

   // Bit 0 of the result is transmitted first.
   function automatic frame_t build_frame(input logic [7:0] first_b,
                                          input logic [7:0] second_b);
      frame_t f;
      for (int i = 0; i < RUNIN_BITS; i++) f[i] = ~i[0];
      f[RUNIN_BITS]   = 1'b0;
      f[RUNIN_BITS+1] = 1'b0;
      f[RUNIN_BITS+2] = 1'b1;
      f[RUNIN_BITS+START_BITS +: BYTE_BITS]             = first_b;
      f[RUNIN_BITS+START_BITS+BYTE_BITS +: BYTE_BITS]   = second_b;
      return f;
   endfunction
endpackage

// File: rtl/cc_byte_regs.sv
module cc_byte_regs #(
   parameter int          N_REGS  = 4,
   parameter logic [7:0]  RST_VAL = 8'h80
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(N_REGS)-1:0] wr_addr,
   input  logic [7:0]                wr_data,
   output logic [N_REGS-1:0][7:0]    regs_q
);
   for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      regs_q[g] <= RST_VAL;
         else if (wr_en && wr_addr == g)  regs_q[g] <= wr_data;
      end

      assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == g) |=> regs_q[g] == $past(wr_data));
      assert_other_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_addr == g) |=> $stable(regs_q[g]));
   end
endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] per_in,
   output logic [DIV_W-1:0] per_len,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         per_len <= DIV_W'(1);
      end else if (start) begin
         cnt     <= '0;
         per_len <= per_in;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + DIV_W'(1);
      end
   end

   assign tick = run && (cnt == per_len - DIV_W'(1));

   assert_tick_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !start) |=> cnt == '0);
   assert_period_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start) |=> $stable(per_len));
endmodule

// File: rtl/cc_frame_shifter.sv
module cc_frame_shifter
   import cc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   tick,
   input  frame_t frame_in,
   output logic   busy,
   output logic   bit_o
);
   localparam int LEFT_W = $clog2(FRAME_LEN + 1);

   frame_t            sh;
   logic [LEFT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
         busy <= 1'b0;
      end else if (start) begin
         sh   <= frame_in;
         left <= LEFT_W'(FRAME_LEN);
         busy <= 1'b1;
      end else if (tick) begin
         sh   <= sh >> 1;
         left <= left - LEFT_W'(1);
         if (left == LEFT_W'(1)) busy <= 1'b0;
      end
   end

   assign bit_o = busy & sh[0];

   assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
   assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(sh));
endmodule

// File: rtl/cc_line_serializer.sv
module cc_line_serializer
   import cc_pkg::*;
#(
   parameter int DIV_W        = 8,
   parameter int DEF_BIT_CLKS = 54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             field_odd,
   input  logic             cap_line,
   input  logic             line_start,
   input  logic [DIV_W-1:0] bit_clks,
   output logic             ser_valid,
   output logic             ser_bit
);
   localparam int VLEN_W = DIV_W + $clog2(FRAME_LEN) + 1;

   if (DEF_BIT_CLKS < 1 || DEF_BIT_CLKS >= (1 << DIV_W)) begin : g_bad_def
      $error("DEF_BIT_CLKS must fit in DIV_W bits and be nonzero");
   end
   if (NUM_REGS != 4) begin : g_bad_regs
      $error("the write port decodes exactly four byte registers");
   end

   logic [NUM_REGS-1:0][7:0] regs_q;
   logic                     start;
   logic                     tick;
   logic [DIV_W-1:0]         per_sel;
   logic [DIV_W-1:0]         per_len;
   frame_t                   frame_next;

   cc_byte_regs #(.N_REGS(NUM_REGS), .RST_VAL(8'h80)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .regs_q(regs_q));

   assign start   = line_start & cap_line & ~ser_valid;
   assign per_sel = (bit_clks == '0) ? DIV_W'(DEF_BIT_CLKS) : bit_clks;

   always_comb begin
      if (field_odd) frame_next = build_frame(regs_q[0], regs_q[1]);
      else           frame_next = build_frame(regs_q[2], regs_q[3]);
   end

   cc_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .run(ser_valid),
      .per_in(per_sel), .per_len(per_len), .tick(tick));

   cc_frame_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .frame_in(frame_next), .busy(ser_valid), .bit_o(ser_bit));

   // Checker: length of the valid window in clocks.
   logic [VLEN_W-1:0] vlen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vlen <= '0;
      else if (start)     vlen <= '0;
      else if (ser_valid) vlen <= vlen + VLEN_W'(1);
   end

   assert_valid_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid) |-> vlen == VLEN_W'(FRAME_LEN) * VLEN_W'(per_len));
   assert_start_raises_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ser_valid);
   assert_runin_first_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ser_bit);
   assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid |-> !ser_bit);
   assert_ignore_no_capline_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_valid && !(line_start && cap_line)) |=> !ser_valid);
endmodule

// File: tb/cc_line_serializer_tb_top.sv
`timescale 1ns/1ps
module cc_line_serializer_tb_top;
   import cc_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       field_odd = 1'b1;
   logic       cap_line = 1'b0;
   logic       line_start = 1'b0;
   logic [7:0] bit_clks = 8'd2;
   logic       ser_valid, ser_bit;

   int checks = 0;
   int failures = 0;
   logic [7:0] model [4];

   always #2 clk = ~clk;

   cc_line_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .field_odd(field_odd), .cap_line(cap_line),
      .line_start(line_start), .bit_clks(bit_clks),
      .ser_valid(ser_valid), .ser_bit(ser_bit));

   function automatic logic [32:0] exp_frame(input logic [7:0] a, input logic [7:0] b);
      logic [32:0] f;
      for (int i = 0; i < 14; i++) f[i] = (i % 2 == 0);
      f[14] = 1'b0; f[15] = 1'b0; f[16] = 1'b1;
      for (int i = 0; i < 8; i++) begin
         f[17+i] = a[i];
         f[25+i] = b[i];
      end
      return f;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; model[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // One frame; optional same-cycle write, mid-frame write, mid-frame restart.
   task automatic run_line(input bit odd, input int per_in, input bit wr_same,
                           input int wr_at, input logic [1:0] wa, input logic [7:0] wd,
                           input int rs_at, input string req);
      logic [32:0] ef;
      int p, errs, bad_k, bad_a, bad_e, verrs;
      ef = odd ? exp_frame(model[0], model[1]) : exp_frame(model[2], model[3]);
      p = (per_in == 0) ? 54 : per_in;
      errs = 0; verrs = 0; bad_k = 0; bad_a = 0; bad_e = 0;
      @(negedge clk);
      field_odd = odd; bit_clks = 8'(per_in); cap_line = 1'b1; line_start = 1'b1;
      if (wr_same) begin
         wr_en = 1'b1; wr_addr = wa; wr_data = wd; model[wa] = wd;
      end
      @(negedge clk);
      for (int k = 0; k < 33; k++) begin
         for (int c = 0; c < p; c++) begin
            if (ser_valid !== 1'b1) verrs++;
            if (ser_bit !== ef[k]) begin
               if (errs == 0) begin bad_k = k; bad_a = int'(ser_bit); bad_e = int'(ef[k]); end
               errs++;
            end
            line_start = 1'b0; wr_en = 1'b0;
            if (c == 0 && k == wr_at) begin
               wr_en = 1'b1; wr_addr = wa; wr_data = wd; model[wa] = wd;
            end
            if (c == 0 && k == rs_at) begin
               line_start = 1'b1; cap_line = 1'b1;
               field_odd = ~field_odd; bit_clks = bit_clks + 8'd1;
            end
            @(negedge clk);
         end
      end
      line_start = 1'b0; wr_en = 1'b0;
      check(errs == 0, {req, " stream bit"}, bad_a, bad_e);
      if (errs != 0) $display("  mismatch at bit %0d", bad_k);
      check(verrs == 0, {req, " R3 valid held"}, verrs, 0);
      check(ser_valid == 1'b0 && ser_bit == 1'b0, {req, " R3 R10 valid ends"},
            int'(ser_valid), 0);
      cap_line = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int dummy;
      dummy = $urandom(32'd20240611);
      for (int i = 0; i < 4; i++) model[i] = 8'h80;
      repeat (3) @(negedge clk);
      check(ser_valid == 1'b0, "R1 reset valid", int'(ser_valid), 0);
      check(ser_bit == 1'b0, "R1 reset bit", int'(ser_bit), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents seen through a frame of each field
      run_line(1'b1, 1, 1'b0, -1, 2'd0, 8'h00, -1, "R1 odd reset bytes");
      run_line(1'b0, 2, 1'b0, -1, 2'd0, 8'h00, -1, "R1 even reset bytes");

      // R2 R5 R6: distinct byte per address, both fields
      reg_write(2'd0, 8'hC1);
      reg_write(2'd1, 8'h52);
      reg_write(2'd2, 8'hA4);
      reg_write(2'd3, 8'h38);
      run_line(1'b1, 3, 1'b0, -1, 2'd0, 8'h00, -1, "R2 R5 R6 odd bytes");
      run_line(1'b0, 3, 1'b0, -1, 2'd0, 8'h00, -1, "R2 R5 R6 even bytes");

      // R4 R6: all-zero and all-one bytes expose run-in and framing edges
      reg_write(2'd0, 8'h00);
      reg_write(2'd1, 8'hFF);
      run_line(1'b1, 1, 1'b0, -1, 2'd0, 8'h00, -1, "R4 R6 extreme bytes");

      // R7: default bit period from bit_clks = 0
      run_line(1'b1, 0, 1'b0, -1, 2'd0, 8'h00, -1, "R7 default period");

      // R9: write in the start cycle keeps old byte, new one next frame
      run_line(1'b0, 2, 1'b1, -1, 2'd2, 8'h6D, -1, "R9 same-cycle write");
      run_line(1'b0, 2, 1'b0, -1, 2'd0, 8'h00, -1, "R9 write seen next frame");

      // R9 R8: mid-frame write, restart strobe, field and period change
      run_line(1'b1, 4, 1'b0, 20, 2'd1, 8'h9E, 10, "R8 R9 mid-frame activity");
      run_line(1'b1, 4, 1'b0, -1, 2'd0, 8'h00, -1, "R9 mid write applied");

      // R8: strobe with cap_line low does nothing
      @(negedge clk);
      cap_line = 1'b0; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      begin
         int seen = 0;
         for (int i = 0; i < 6; i++) begin
            if (ser_valid) seen++;
            @(negedge clk);
         end
         check(seen == 0, "R8 no start without cap_line", seen, 0);
      end

      // Random frames
      for (int n = 0; n < 24; n++) begin
         logic [1:0] a;
         a = 2'($urandom_range(0, 3));
         reg_write(a, 8'($urandom));
         run_line(1'($urandom), int'($urandom_range(1, 5)), 1'($urandom_range(0, 1)),
                  (n % 3 == 0) ? int'($urandom_range(0, 32)) : -1,
                  2'($urandom_range(0, 3)), 8'($urandom),
                  (n % 4 == 1) ? int'($urandom_range(1, 32)) : -1,
                  "R5 R6 R9 random");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule